// File: doc/BRIEF.md
# Serial PHY Management Controller

This block is a register-mapped master for the two-wire PHY management bus (MDC clock plus bidirectional MDIO data). Software picks a PHY address and a register number and writes a single command word. The block then clocks out one complete management frame. It shows a busy flag while the frame is running. For a read, it places the 16 bits returned by the PHY in a data register.

A control register sets the MDC divisor and can turn on preamble suppression. A self-clearing soft reset in the same register aborts any frame in flight and restores the default settings. The data pin is split into an output value, an output enable and an input, so the tri-state buffer sits outside the block.

The register interface is 16 bits wide. It has four word addresses: 0 command, 1 data, 2 status, 3 control. Read data is registered and appears one clock after the address is presented.

Top module: `mgmt_serial_master`

## Requirements
- R1: A write to address 0 with bit 15 set starts a read frame. With bit 14 set (and bit 15 clear) it starts a write frame. With both bits set it starts a read frame. With neither bit set, no frame starts. Bits 9:5 carry the PHY address and bits 4:0 the register number.
- R2: A frame is sent MSB first on `mdio_out`. In order it holds: 32 ones of preamble, start 01, opcode 10 for read or 01 for write, the 5-bit PHY address, the 5-bit register number, a 2-bit turnaround, and 16 data bits. `mdio_out` changes only while MDC is low.
- R3: Status bit 0 (address 2) reads 1 from the clock after an accepted command until the frame's last MDC period ends, and 0 otherwise.
- R4: On a read, `mdio_oe` is 0 from the first turnaround bit to the end of the frame. The PHY's 16 bits are sampled on rising MDC edges. After completion the data register (address 1, bits 15:0) holds them.
- R5: On a write, the turnaround is sent as 10 and the data field is the data register's value at the moment the command is written.
- R6: The MDC period is (field+1) system clocks, where field is control bits 15:9. A field of 0 gives a period of 2. Each period is low for floor(period/2) clocks and high for the rest. MDC stays low when no frame is running. The divisor is latched when the frame starts.
- R7: With control bit 8 set, the preamble is left out and a frame has 32 MDC periods instead of 64.
- R8: A command written while a frame is running is ignored, and the running frame completes unchanged.
- R9: The data register changes only on a software write to address 1, on completion of a read, or by reset.
- R10: Writing control bit 0 as 1 starts a soft reset. Bit 0 reads 1 for SRST_CYCLES clocks and then clears. The reset stops any frame, with MDC held low. It sets the divisor field to DEF_DIV_M1 (39) and clears preamble suppression and the data register.
- R11: After `rst`, the status, data and control registers read 0, 0 and DEF_DIV_M1<<9, and MDC and `mdio_oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data for reg_addr |
| mdc | output | 1 | Management clock to the PHY |
| mdio_out | output | 1 | Data value driven onto MDIO |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_in | input | 1 | Data sampled from MDIO |

## Verification
Frames are run with read and write opcodes, extreme PHY and register fields (all zeros, all ones, alternating), and divisors of 2, 3, 4, 6 and 40, with the preamble both present and suppressed. Odd divisors separate a correct low/high split from an off-by-one, and divisor 2 exposes a data sample that coincides with the end of a bit. Capturing every bit on the rising MDC edge shows the frame layout, the release of the data pin and the preamble length. Directed cases cover a command with no opcode bit, a command with both opcode bits, a command issued during a frame, and a soft reset in mid-frame.

// File: rtl/mgmt_pkg.sv
`timescale 1ns/1ps
package mgmt_pkg;
  localparam int FRAME_BITS = 64;
  localparam int PRE_BITS   = 32;
  localparam int TA_POS     = 46;
  localparam int DATA_POS   = 48;
  localparam int POS_W      = $clog2(FRAME_BITS);

  localparam logic [1:0] A_CMD  = 2'd0;
  localparam logic [1:0] A_DATA = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;
  localparam logic [1:0] A_CTRL = 2'd3;

  // full frame image, first bit on the wire at the MSB
  function automatic logic [FRAME_BITS-1:0] build_frame(input logic rd, input logic [4:0] phy,
                                                        input logic [4:0] regn, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, regn,
            (rd ? 2'b00 : 2'b10), (rd ? 16'h0000 : d)};
  endfunction
endpackage

// File: rtl/mgmt_mdc_gen.sv
`timescale 1ns/1ps
module mgmt_mdc_gen #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div_m1,
  output logic             mdc,
  output logic             samp_tk,
  output logic             bit_end
);
  localparam int CW = DIV_W + 1;

  logic [CW-1:0] dval, lo, cnt, cnt_nx;

  assign dval    = (div_m1 == '0) ? CW'(2) : CW'(div_m1) + CW'(1);
  assign lo      = dval >> 1;
  assign cnt_nx  = (cnt == dval - CW'(1)) ? '0 : cnt + CW'(1);
  assign samp_tk = run && (cnt == lo);
  assign bit_end = run && (cnt == dval - CW'(1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else begin
      cnt <= cnt_nx;
      mdc <= (cnt_nx >= lo);
    end
  end

  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (rst) !run |=> !mdc); // R6
endmodule

// File: rtl/mgmt_frame_eng.sv
`timescale 1ns/1ps
module mgmt_frame_eng
  import mgmt_pkg::*;
#(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  logic             launch_rd,
  input  logic [4:0]       phy,
  input  logic [4:0]       regn,
  input  logic [15:0]      wdata,
  input  logic             no_pre,
  input  logic [DIV_W-1:0] div_in,
  input  logic             samp_tk,
  input  logic             bit_end,
  input  logic             mdio_in,
  output logic             busy,
  output logic [DIV_W-1:0] div_q,
  output logic             mdio_out,
  output logic             mdio_oe,
  output logic             rd_done,
  output logic [15:0]      rd_data
);
  logic [FRAME_BITS-1:0] sh;
  logic [POS_W-1:0]      pos;
  logic                  rd_q;
  logic [15:0]           rsh, rsh_nx;

  assign rsh_nx   = (busy && samp_tk && rd_q && pos >= POS_W'(DATA_POS)) ? {rsh[14:0], mdio_in} : rsh;
  assign mdio_out = sh[FRAME_BITS-1];
  assign mdio_oe  = busy && !(rd_q && pos >= POS_W'(TA_POS));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      sh      <= '0;
      pos     <= '0;
      rd_q    <= 1'b0;
      rsh     <= '0;
      div_q   <= '0;
      rd_done <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_done <= 1'b0;
      if (launch && !busy) begin
        busy  <= 1'b1;
        rd_q  <= launch_rd;
        div_q <= div_in;
        rsh   <= '0;
        if (no_pre) begin
          sh  <= build_frame(launch_rd, phy, regn, wdata) << PRE_BITS;
          pos <= POS_W'(PRE_BITS);
        end else begin
          sh  <= build_frame(launch_rd, phy, regn, wdata);
          pos <= '0;
        end
      end else if (busy) begin
        rsh <= rsh_nx;
        if (bit_end) begin
          if (pos == POS_W'(FRAME_BITS - 1)) begin
            busy <= 1'b0;
            sh   <= '0;
            if (rd_q) begin
              rd_done <= 1'b1;
              rd_data <= rsh_nx;
            end
          end else begin
            pos <= pos + POS_W'(1);
            sh  <= sh << 1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/mgmt_srst_seq.sv
`timescale 1ns/1ps
module mgmt_srst_seq #(
  parameter int CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic active
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;

  assign active = (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst)                 cnt <= '0;
    else if (start && !active) cnt <= CW'(CYCLES);
    else if (active)         cnt <= cnt - CW'(1);
  end

  AST_SRST_START: assert property (@(posedge clk) disable iff (rst) (start && !active) |=> active); // R10
endmodule

// File: rtl/mgmt_serial_master.sv
`timescale 1ns/1ps
module mgmt_serial_master
  import mgmt_pkg::*;
#(
  parameter int DW          = 16,
  parameter int DIV_W       = 7,
  parameter int DEF_DIV_M1  = 39,
  parameter int SRST_CYCLES = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          mdc,
  output logic          mdio_out,
  output logic          mdio_oe,
  input  logic          mdio_in
);
  localparam int DIV_LSB = 9;

  logic             srst_act, srst_start, eng_rst;
  logic             cmd_hit, data_wr, ctrl_wr;
  logic             eng_busy, eng_rd_done, samp_tk, bit_end;
  logic [15:0]      eng_rd_data, data_q;
  logic [DIV_W-1:0] div_r, eng_div;
  logic             nopre_r;
  logic             unused_bits;

  assign cmd_hit    = reg_we && reg_addr == A_CMD && (reg_wdata[15] || reg_wdata[14]) && !srst_act;
  assign data_wr    = reg_we && reg_addr == A_DATA && !srst_act;
  assign ctrl_wr    = reg_we && reg_addr == A_CTRL && !srst_act;
  assign srst_start = ctrl_wr && reg_wdata[0];
  assign eng_rst    = rst || srst_act;
  assign unused_bits = ^{reg_wdata[13:10], reg_wdata[7:1]};

  mgmt_srst_seq #(.CYCLES(SRST_CYCLES)) u_srst (
    .clk(clk), .rst(rst), .start(srst_start), .active(srst_act));

  mgmt_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
    .clk(clk), .rst(eng_rst), .run(eng_busy), .div_m1(eng_div),
    .mdc(mdc), .samp_tk(samp_tk), .bit_end(bit_end));

  mgmt_frame_eng #(.DIV_W(DIV_W)) u_eng (
    .clk(clk), .rst(eng_rst), .launch(cmd_hit), .launch_rd(reg_wdata[15]),
    .phy(reg_wdata[9:5]), .regn(reg_wdata[4:0]), .wdata(data_q), .no_pre(nopre_r),
    .div_in(div_r), .samp_tk(samp_tk), .bit_end(bit_end), .mdio_in(mdio_in),
    .busy(eng_busy), .div_q(eng_div), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
    .rd_done(eng_rd_done), .rd_data(eng_rd_data));

  always_ff @(posedge clk) begin
    if (rst || srst_act) begin
      data_q  <= '0;
      div_r   <= DIV_W'(DEF_DIV_M1);
      nopre_r <= 1'b0;
    end else begin
      if (eng_rd_done)  data_q <= eng_rd_data;
      else if (data_wr) data_q <= reg_wdata[15:0];
      if (ctrl_wr && !reg_wdata[0]) begin
        div_r   <= reg_wdata[DIV_LSB +: DIV_W];
        nopre_r <= reg_wdata[8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_addr)
        A_DATA:  reg_rdata <= DW'(data_q);
        A_STAT:  reg_rdata <= DW'(eng_busy);
        A_CTRL:  reg_rdata <= DW'({div_r, nopre_r, 7'b0, srst_act});
        default: reg_rdata <= '0;
      endcase
    end
  end

  AST_BUSY_ON_CMD: assert property (@(posedge clk) disable iff (rst)
    (cmd_hit && !eng_busy) |=> eng_busy); // R3
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!data_wr && !eng_rd_done && !srst_act) |=> $stable(data_q)); // R9
  AST_OE_FALL_LOW: assert property (@(posedge clk) disable iff (rst || srst_act)
    $fell(mdio_oe) |-> !mdc); // R4
endmodule

// File: tb/mgmt_serial_master_bench.sv
`timescale 1ns/1ps
module mgmt_serial_master_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic        mdc, mdio_out, mdio_oe;
  logic        mdio_in = 1'b1;

  int checks = 0, fails = 0, cyc = 0;
  int nrise = 0, base = 0;
  logic [15:0] phy_val = 16'h0;
  logic cap_out [64];
  logic cap_oe  [64];
  time t0 = 0, t1 = 0;

  always #2 clk = ~clk;

  mgmt_serial_master u_mgmt_serial_master (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in));

  // simple PHY responder
  always @(posedge mdc) begin
    if (nrise < 64) begin
      cap_out[nrise] = mdio_out;
      cap_oe[nrise]  = mdio_oe;
    end
    if (nrise == 0) t0 = $time;
    if (nrise == 1) t1 = $time;
    nrise++;
  end
  always @(negedge mdc) begin
    int k;
    k = nrise + base;
    mdio_in = (k >= 48 && k < 64) ? phy_val[63-k] : 1'b1;
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL R3 watchdog: act=running exp=finished");
      summary();
      $finish;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic bus_rd(logic [1:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a;
    @(posedge clk); #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    for (int i = 0; i < 20000; i++) begin
      bus_rd(2'd2, s);
      if (s[0] == 1'b0) break;
    end
  endtask

  function automatic logic [63:0] exp_frame(logic rd, logic [4:0] phy, logic [4:0] rg, logic [15:0] d);
    logic [63:0] f;
    f = '1;
    f[31:30] = 2'b01;
    f[29:28] = rd ? 2'b10 : 2'b01;
    f[27:23] = phy;
    f[22:18] = rg;
    f[17:16] = rd ? 2'b00 : 2'b10;
    f[15:0]  = rd ? 16'h0 : d;
    return f;
  endfunction

  task automatic run_frame(logic rd, logic [4:0] phy, logic [4:0] rg, logic [15:0] wd,
                           logic [15:0] pv, logic [6:0] dv, logic np);
    logic [15:0] s;
    logic [63:0] ef;
    int bad, dexp;
    bus_wr(2'd3, {dv, np, 8'h00});
    if (!rd) bus_wr(2'd1, wd);
    phy_val = pv; base = np ? 32 : 0; nrise = 0;
    bus_wr(2'd0, {rd, !rd, 4'h0, phy, rg});
    bus_rd(2'd2, s);
    chk("R3 busy after command", 32'(s[0]), 32'd1);
    wait_idle();
    repeat (4) @(posedge clk);
    chk("R7 MDC periods per frame", nrise, 64 - base);
    dexp = (dv == 0) ? 2 : int'(dv) + 1;
    chk("R6 MDC period", 32'((t1 - t0) / 4), dexp);
    ef = exp_frame(rd, phy, rg, wd);
    bad = 0;
    for (int k = 0; k < 64 - base; k++) begin
      if (rd && base + k >= 46) begin
        if (cap_oe[k] !== 1'b0) bad++;
      end else if (cap_oe[k] !== 1'b1 || cap_out[k] !== ef[63-base-k]) bad++;
    end
    chk(rd ? "R4 R2 read frame bits" : "R5 R2 write frame bits", bad, 0);
    bus_rd(2'd1, s);
    chk(rd ? "R4 read data captured" : "R9 data kept after write", 32'(s), 32'(rd ? pv : wd));
  endtask

  // rd, phy, reg, wdata, phy reply, divisor-1, no preamble
  localparam logic [50:0] VEC [6] = '{
    {1'b0, 5'd1,  5'd0,  16'h1234, 16'h0000, 7'd3,  1'b0},
    {1'b1, 5'd31, 5'd31, 16'h0000, 16'hA5C3, 7'd1,  1'b0},
    {1'b1, 5'd0,  5'd1,  16'h0000, 16'hFFFF, 7'd2,  1'b1},
    {1'b0, 5'd21, 5'd10, 16'h8001, 16'h0000, 7'd0,  1'b1},
    {1'b1, 5'd10, 5'd21, 16'h0000, 16'h0001, 7'd39, 1'b0},
    {1'b0, 5'd5,  5'd17, 16'hFFFF, 16'h0000, 7'd5,  1'b0}
  };

  initial begin
    logic [15:0] s;
    int n0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R11 reset state
    bus_rd(2'd3, s); chk("R11 control after reset", 32'(s), 32'(16'd39 << 9));
    bus_rd(2'd1, s); chk("R11 data after reset", 32'(s), 32'd0);
    bus_rd(2'd2, s); chk("R11 status after reset", 32'(s), 32'd0);
    chk("R11 pins after reset", {30'd0, mdc, mdio_oe}, 32'd0);

    for (int v = 0; v < 6; v++)
      run_frame(VEC[v][50], VEC[v][49:45], VEC[v][44:40], VEC[v][39:24],
                VEC[v][23:8], VEC[v][7:1], VEC[v][0]);

    // R1 command without opcode bits
    nrise = 0;
    bus_wr(2'd0, 16'h03FF);
    repeat (10) @(posedge clk);
    bus_rd(2'd2, s); chk("R1 no opcode stays idle", 32'(s[0]), 32'd0);
    chk("R1 no opcode no MDC", nrise, 0);

    // R1 both opcode bits -> read
    bus_wr(2'd3, 16'h0200);
    phy_val = 16'h3C3C; base = 0; nrise = 0;
    bus_wr(2'd0, 16'hC000 | (16'd2 << 5) | 16'd7);
    wait_idle(); repeat (4) @(posedge clk);
    bus_rd(2'd1, s); chk("R1 both bits read data", 32'(s), 32'h3C3C);
    chk("R1 both bits released pin", 32'(cap_oe[63]), 32'd0);

    // R8 command while busy ignored
    phy_val = 16'h5A5A; nrise = 0;
    bus_wr(2'd0, 16'h8000 | (16'd3 << 5) | 16'd4);
    bus_wr(2'd0, 16'h4000 | (16'd9 << 5) | 16'd9);
    wait_idle(); repeat (4) @(posedge clk);
    chk("R8 single frame only", nrise, 64);
    bus_rd(2'd1, s); chk("R8 first frame result", 32'(s), 32'h5A5A);

    // R9 software write to data register
    bus_wr(2'd1, 16'hBEEF);
    bus_rd(2'd1, s); chk("R9 data write", 32'(s), 32'hBEEF);

    // R10 soft reset in mid-frame
    bus_wr(2'd3, 16'h0500);
    nrise = 0;
    bus_wr(2'd0, 16'h4000 | 16'd3);
    repeat (30) @(posedge clk);
    bus_wr(2'd3, 16'h0001);
    bus_rd(2'd3, s); chk("R10 reset bit set", 32'(s[0]), 32'd1);
    repeat (20) @(posedge clk);
    n0 = nrise;
    bus_rd(2'd3, s); chk("R10 control defaults", 32'(s), 32'(16'd39 << 9));
    bus_rd(2'd2, s); chk("R10 frame aborted", 32'(s), 32'd0);
    bus_rd(2'd1, s); chk("R10 data cleared", 32'(s), 32'd0);
    repeat (100) @(posedge clk);
    chk("R10 MDC stopped", nrise, n0);
    chk("R10 MDC low", 32'(mdc), 32'd0);

    summary();
    $finish;
  end
endmodule